// File: doc/BRIEF.md
# Clock Frequency Meter and Monitor

This block supervises the clocks of a chip from a register-clock domain. Its first function is a frequency meter: software programs a window length in cycles of a slow internal RC clock, sets a start bit, and the block counts how many cycles of a trusted reference oscillator fall inside that window. When the count is ready the block stores it in a result register and clears the start bit, so software can poll the bit and then compute the RC frequency as reference frequency multiplied by window length and divided by the stored count.

The second function is a clock monitor. A free-running window, a fixed number of reference cycles long, gates a counter running on the monitored clock. Each completed count is compared against a programmable upper limit and lower limit. Independently, the register clock watches a divided copy of the reference clock and declares the oscillator lost when no edge arrives within a fixed number of its own cycles. Each condition sets a sticky fault flag that is both readable and driven on a dedicated output. All crossings between the four clock domains use two-flop synchronizers. Single-bit events are passed as toggles, and multi-bit counts are held stable until their toggle has been seen.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset every register reads zero and all three fault outputs are low. Register addresses: 0 control, 1 duration, 2 result, 3 upper limit, 4 lower limit, 5 faults.
- R2: Writing control bit 0 as 1 while it reads 0 starts a measurement. The bit reads 1 until the result is loaded and then reads 0 without any further write.
- R3: The result register (address 2) holds the number of reference-clock cycles that elapse during the programmed number of RC-clock cycles, within one cycle.
- R4: The duration register (address 1) is 20 bits wide, so write bits above bit 19 are dropped. A duration of 0 measures over one RC cycle.
- R5: A start write while a measurement runs is ignored, and so is a duration write made after the start. The result reflects the duration captured at the start, and no second measurement follows.
- R6: With monitoring enabled, a monitored-clock count above the upper limit (address 3) sets fault bit 0 and output flt_fast.
- R7: With monitoring enabled, a monitored-clock count below the lower limit (address 4) sets fault bit 1 and output flt_slow.
- R8: With monitoring enabled, the absence of any divided-reference edge for 64 register-clock cycles sets fault bit 2 and output flt_ref_lost. Counts that lie within the limits, and a running reference, set nothing.
- R9: While control bit 1 (monitor enable) is 0, no fault flag is set, whatever the clocks and limits are.
- R10: Fault flags stay set after their cause disappears. Writing 1 to a fault bit at address 5 clears it.
- R11: The oscillator divider, control bits 5:4, selects one reference edge per 2^value cycles. It accepts a write only while monitor enable reads 0, so a write made while enabled leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Register and supervision clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| clk_ref | input | 1 | Trusted reference oscillator clock |
| clk_rc | input | 1 | Internal RC clock under measurement |
| clk_mon | input | 1 | Clock checked against the limits |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| flt_fast | output | 1 | Sticky fault, monitored clock above upper limit |
| flt_slow | output | 1 | Sticky fault, monitored clock below lower limit |
| flt_ref_lost | output | 1 | Sticky fault, reference clock missing |

## Verification
The bench builds the block with its default parameters: a 20-bit duration, a 64-cycle monitor window followed by a 16-cycle gap, and a 64-cycle loss limit. It runs the four clocks at fixed, unrelated periods of 5, 8, 20 and 10 ns. These values put the expected meter counts (250 for 100 RC cycles, about 92 for 37, about 2 for a zero duration) and the monitor count of about 51 within a few thousand register cycles. That makes it possible to push the count across each limit, to observe the stickiness after the limit is restored, and finally to stop the reference clock and see the loss fault.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_DUR    = 3'd1,
    REG_RESULT = 3'd2,
    REG_HI     = 3'd3,
    REG_LO     = 3'd4,
    REG_FAULT  = 3'd5
  } cfm_reg_e;

  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_EN_BIT  = 1;
  localparam int CTRL_DIV_LSB = 4;
  localparam int DIV_W        = 2;

  localparam int FLT_FAST = 0;
  localparam int FLT_SLOW = 1;
  localparam int FLT_LOST = 2;

endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/cfm_shot_gate.sv
module cfm_shot_gate #(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_tgl,
  input  logic [LEN_W-1:0] len,
  output logic             gate
);

  logic             tgl_s;
  logic             tgl_prev_q, tgl_prev_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             gate_q, gate_n;
  logic             trig;

  cfm_sync #(.W(1), .STAGES(2)) u_start_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (start_tgl),
    .q    (tgl_s)
  );

  always_comb begin
    tgl_prev_n = tgl_s;
    trig       = (tgl_s != tgl_prev_q);
    rem_n      = rem_q;
    gate_n     = gate_q;
    if (gate_q) begin
      if (rem_q == LEN_W'(1)) begin
        gate_n = 1'b0;
        rem_n  = '0;
      end else begin
        rem_n = rem_q - 1'b1;
      end
    end else if (trig) begin
      gate_n = 1'b1;
      rem_n  = (len == '0) ? LEN_W'(1) : len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_prev_q <= 1'b0;
      rem_q      <= '0;
      gate_q     <= 1'b0;
    end else begin
      tgl_prev_q <= tgl_prev_n;
      rem_q      <= rem_n;
      gate_q     <= gate_n;
    end
  end

  assign gate = gate_q;

  AST_SHOT_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (rem_q != '0)); // R4

  AST_SHOT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && rem_q == LEN_W'(1)) |=> !gate_q); // R3

endmodule

// File: rtl/cfm_tick_gate.sv
module cfm_tick_gate #(
  parameter int WIN_LEN = 64,
  parameter int WIN_GAP = 16,
  parameter int DIV_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             gate,
  output logic             alive_tgl
);

  localparam int PERIOD = WIN_LEN + WIN_GAP;
  localparam int PW     = $clog2(PERIOD);
  localparam int PRE_W  = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] div_s;
  logic [PW-1:0]    ph_q, ph_n;
  logic             gate_q, gate_n;
  logic [PRE_W-1:0] pre_q, pre_n, pre_lim;
  logic             alive_q, alive_n;

  cfm_sync #(.W(DIV_W), .STAGES(2)) u_div_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (div),
    .q    (div_s)
  );

  always_comb begin
    for (int i = 0; i < PRE_W; i++) pre_lim[i] = (i < int'(div_s));
    ph_n    = (ph_q == PW'(PERIOD - 1)) ? '0 : ph_q + 1'b1;
    gate_n  = (ph_n < PW'(WIN_LEN));
    pre_n   = pre_q + 1'b1;
    alive_n = alive_q;
    if (pre_q >= pre_lim) begin
      pre_n   = '0;
      alive_n = ~alive_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      gate_q  <= 1'b0;
      pre_q   <= '0;
      alive_q <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      gate_q  <= gate_n;
      pre_q   <= pre_n;
      alive_q <= alive_n;
    end
  end

  assign gate      = gate_q;
  assign alive_tgl = alive_q;

  AST_WIN_WRAP_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PW'(PERIOD - 1)) |=> (ph_q == '0)); // R6

endmodule

// File: rtl/cfm_gate_count.sv
module cfm_gate_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_in,
  output logic [CNT_W-1:0] cnt,
  output logic             done_tgl
);

  logic             gate_s;
  logic             gate_d_q, gate_d_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;

  cfm_sync #(.W(1), .STAGES(2)) u_gate_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (gate_in),
    .q    (gate_s)
  );

  always_comb begin
    gate_d_n = gate_s;
    cnt_n    = cnt_q;
    done_n   = done_q;
    if (gate_s && !gate_d_q) begin
      cnt_n = CNT_W'(1);
    end else if (gate_s) begin
      if (cnt_q != '1) cnt_n = cnt_q + 1'b1;
    end else if (gate_d_q) begin
      done_n = ~done_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      gate_d_q <= gate_d_n;
      cnt_q    <= cnt_n;
      done_q   <= done_n;
    end
  end

  assign cnt      = cnt_q;
  assign done_tgl = done_q;

  AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_s && !gate_d_q) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
  import cfm_pkg::*;
#(
  parameter int DUR_W    = 20,
  parameter int CNT_W    = 32,
  parameter int MON_W    = 16,
  parameter int WIN_LEN  = 64,
  parameter int WIN_GAP  = 16,
  parameter int LOSS_LIM = 64,
  parameter int DATA_W   = 32
) (
  input  logic              clk_sys,
  input  logic              rst_n,
  input  logic              clk_ref,
  input  logic              clk_rc,
  input  logic              clk_mon,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              flt_fast,
  output logic              flt_slow,
  output logic              flt_ref_lost
);

  localparam int LW = $clog2(LOSS_LIM + 1);

  logic rs_sys, rs_ref, rs_rc, rs_mon;

  cfm_sync #(.W(1), .STAGES(2)) u_rs_sys (.clk(clk_sys), .rst_n(rst_n), .d(1'b1), .q(rs_sys));
  cfm_sync #(.W(1), .STAGES(2)) u_rs_ref (.clk(clk_ref), .rst_n(rst_n), .d(1'b1), .q(rs_ref));
  cfm_sync #(.W(1), .STAGES(2)) u_rs_rc  (.clk(clk_rc),  .rst_n(rst_n), .d(1'b1), .q(rs_rc));
  cfm_sync #(.W(1), .STAGES(2)) u_rs_mon (.clk(clk_mon), .rst_n(rst_n), .d(1'b1), .q(rs_mon));

  // register-domain state
  logic             go_q, go_n;
  logic             en_q, en_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [DUR_W-1:0] dur_q, dur_n;
  logic [DUR_W-1:0] hold_q, hold_n;
  logic [CNT_W-1:0] res_q, res_n;
  logic [MON_W-1:0] hi_q, hi_n;
  logic [MON_W-1:0] lo_q, lo_n;
  logic             fast_q, fast_n;
  logic             slow_q, slow_n;
  logic             lost_q, lost_n;
  logic             start_tgl_q, start_tgl_n;
  logic [LW-1:0]    loss_cnt_q, loss_cnt_n;
  logic [2:0]       ev_prev_q, ev_prev_n;

  // cross-domain wires
  logic             rc_gate;
  logic [CNT_W-1:0] meas_cnt;
  logic             meas_tgl;
  logic             win_gate;
  logic             alive_tgl;
  logic [MON_W-1:0] mon_cnt;
  logic             mon_tgl;
  logic [2:0]       ev_s;

  logic             wr_ctrl, wr_dur, wr_hi, wr_lo, wr_flt;
  logic             start_evt, meas_evt, mon_evt, alive_evt;
  logic [2:0]       clr;
  logic             wdata_unused;

  cfm_shot_gate #(.LEN_W(DUR_W)) u_shot (
    .clk      (clk_rc),
    .rst_n    (rs_rc),
    .start_tgl(start_tgl_q),
    .len      (hold_q),
    .gate     (rc_gate)
  );

  cfm_gate_count #(.CNT_W(CNT_W)) u_meas_cnt (
    .clk     (clk_ref),
    .rst_n   (rs_ref),
    .gate_in (rc_gate),
    .cnt     (meas_cnt),
    .done_tgl(meas_tgl)
  );

  cfm_tick_gate #(.WIN_LEN(WIN_LEN), .WIN_GAP(WIN_GAP), .DIV_W(DIV_W)) u_tick (
    .clk      (clk_ref),
    .rst_n    (rs_ref),
    .div      (div_q),
    .gate     (win_gate),
    .alive_tgl(alive_tgl)
  );

  cfm_gate_count #(.CNT_W(MON_W)) u_mon_cnt (
    .clk     (clk_mon),
    .rst_n   (rs_mon),
    .gate_in (win_gate),
    .cnt     (mon_cnt),
    .done_tgl(mon_tgl)
  );

  cfm_sync #(.W(3), .STAGES(2)) u_ev_sync (
    .clk  (clk_sys),
    .rst_n(rs_sys),
    .d    ({alive_tgl, mon_tgl, meas_tgl}),
    .q    (ev_s)
  );

  assign wdata_unused = ^wdata[DATA_W-1:DUR_W];

  always_comb begin
    wr_ctrl   = wr_en && (addr == REG_CTRL);
    wr_dur    = wr_en && (addr == REG_DUR);
    wr_hi     = wr_en && (addr == REG_HI);
    wr_lo     = wr_en && (addr == REG_LO);
    wr_flt    = wr_en && (addr == REG_FAULT);
    clr       = wr_flt ? wdata[2:0] : 3'b000;

    meas_evt  = ev_s[0] != ev_prev_q[0];
    mon_evt   = ev_s[1] != ev_prev_q[1];
    alive_evt = ev_s[2] != ev_prev_q[2];
    ev_prev_n = ev_s;

    start_evt   = wr_ctrl && wdata[CTRL_GO_BIT] && !go_q;
    start_tgl_n = start_tgl_q ^ start_evt;
    hold_n      = start_evt ? dur_q : hold_q;

    go_n  = go_q;
    res_n = res_q;
    if (go_q && meas_evt) begin
      go_n  = 1'b0;
      res_n = meas_cnt;
    end else if (start_evt) begin
      go_n = 1'b1;
    end

    en_n  = wr_ctrl ? wdata[CTRL_EN_BIT] : en_q;
    div_n = (wr_ctrl && !en_q) ? wdata[CTRL_DIV_LSB +: DIV_W] : div_q;
    dur_n = wr_dur ? wdata[DUR_W-1:0] : dur_q;
    hi_n  = wr_hi  ? wdata[MON_W-1:0] : hi_q;
    lo_n  = wr_lo  ? wdata[MON_W-1:0] : lo_q;

    if (alive_evt)                        loss_cnt_n = '0;
    else if (loss_cnt_q != LW'(LOSS_LIM)) loss_cnt_n = loss_cnt_q + 1'b1;
    else                                  loss_cnt_n = loss_cnt_q;

    fast_n = (fast_q & ~clr[FLT_FAST]) | (en_q & mon_evt & (mon_cnt > hi_q));
    slow_n = (slow_q & ~clr[FLT_SLOW]) | (en_q & mon_evt & (mon_cnt < lo_q));
    lost_n = (lost_q & ~clr[FLT_LOST]) | (en_q & (loss_cnt_n == LW'(LOSS_LIM)));
  end

  always_ff @(posedge clk_sys or negedge rs_sys) begin
    if (!rs_sys) begin
      go_q        <= 1'b0;
      en_q        <= 1'b0;
      div_q       <= '0;
      dur_q       <= '0;
      hold_q      <= '0;
      res_q       <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      fast_q      <= 1'b0;
      slow_q      <= 1'b0;
      lost_q      <= 1'b0;
      start_tgl_q <= 1'b0;
      loss_cnt_q  <= '0;
      ev_prev_q   <= '0;
    end else begin
      go_q        <= go_n;
      en_q        <= en_n;
      div_q       <= div_n;
      dur_q       <= dur_n;
      hold_q      <= hold_n;
      res_q       <= res_n;
      hi_q        <= hi_n;
      lo_q        <= lo_n;
      fast_q      <= fast_n;
      slow_q      <= slow_n;
      lost_q      <= lost_n;
      start_tgl_q <= start_tgl_n;
      loss_cnt_q  <= loss_cnt_n;
      ev_prev_q   <= ev_prev_n;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_CTRL: begin
        rdata[CTRL_GO_BIT]                = go_q;
        rdata[CTRL_EN_BIT]                = en_q;
        rdata[CTRL_DIV_LSB +: DIV_W]      = div_q;
      end
      REG_DUR:    rdata = DATA_W'(dur_q);
      REG_RESULT: rdata = DATA_W'(res_q);
      REG_HI:     rdata = DATA_W'(hi_q);
      REG_LO:     rdata = DATA_W'(lo_q);
      REG_FAULT: begin
        rdata[FLT_FAST] = fast_q;
        rdata[FLT_SLOW] = slow_q;
        rdata[FLT_LOST] = lost_q;
      end
      default: rdata = '0;
    endcase
  end

  assign flt_fast     = fast_q;
  assign flt_slow     = slow_q;
  assign flt_ref_lost = lost_q;

  AST_BUSY_HOLD: assert property (@(posedge clk_sys) disable iff (!rs_sys)
    (go_q && !meas_evt) |=> go_q); // R5

  AST_DONE_CLEARS_GO: assert property (@(posedge clk_sys) disable iff (!rs_sys)
    (go_q && meas_evt) |=> (!go_q && res_q == $past(meas_cnt))); // R2

  AST_HOLD_STABLE_BUSY: assert property (@(posedge clk_sys) disable iff (!rs_sys)
    go_q |=> $stable(hold_q)); // R5

  AST_FAST_STICKY: assert property (@(posedge clk_sys) disable iff (!rs_sys)
    (fast_q && !clr[FLT_FAST]) |=> fast_q); // R10

  AST_SLOW_STICKY: assert property (@(posedge clk_sys) disable iff (!rs_sys)
    (slow_q && !clr[FLT_SLOW]) |=> slow_q); // R10

  AST_FAST_NEEDS_EN: assert property (@(posedge clk_sys) disable iff (!rs_sys)
    $rose(fast_q) |-> $past(en_q)); // R9

  AST_SLOW_NEEDS_EN: assert property (@(posedge clk_sys) disable iff (!rs_sys)
    $rose(slow_q) |-> $past(en_q)); // R9

  AST_LOST_NEEDS_EN: assert property (@(posedge clk_sys) disable iff (!rs_sys)
    $rose(lost_q) |-> ($past(en_q) && !alive_evt)); // R8

  AST_DIV_LOCKED: assert property (@(posedge clk_sys) disable iff (!rs_sys)
    en_q |=> $stable(div_q)); // R11

endmodule

// File: tb/sim_clk_freq_meter.sv
`timescale 1ns/1ps
module sim_clk_freq_meter;

  logic        clk_sys = 1'b0;
  logic        clk_ref = 1'b0;
  logic        clk_rc  = 1'b0;
  logic        clk_mon = 1'b0;
  logic        ref_run = 1'b1;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        flt_fast, flt_slow, flt_ref_lost;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  localparam int WD_LIMIT = 150000;

  always #2.5 clk_sys = ~clk_sys;
  always #4   clk_ref = ref_run ? ~clk_ref : clk_ref;
  always #10  clk_rc  = ~clk_rc;
  always #5   clk_mon = ~clk_mon;

  clk_freq_meter u0 (
    .clk_sys     (clk_sys),
    .rst_n       (rst_n),
    .clk_ref     (clk_ref),
    .clk_rc      (clk_rc),
    .clk_mon     (clk_mon),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .flt_fast    (flt_fast),
    .flt_slow    (flt_slow),
    .flt_ref_lost(flt_ref_lost)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk_sys) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_sys);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk_sys);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk_sys);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_sys);
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd0, v);
      if (v[0] == 1'b0) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  // expected reference count over n RC cycles: n * 20 ns / 8 ns
  function automatic longint ref_cycles_x2(input longint n);
    return (n * 20 * 2) / 8;
  endfunction

  task automatic measure(input string tag, input longint n, input longint tol);
    logic [31:0] v;
    bit ok;
    longint exp2;
    wr(3'd1, 32'(n));
    wr(3'd0, 32'h1);
    wait_done(ok);
    chk({tag, " done"}, longint'(ok), 1, 1);
    rd(3'd2, v);
    exp2 = ref_cycles_x2((n == 0) ? 1 : n);
    chk(tag, longint'(v), exp2 / 2 - tol, (exp2 + 1) / 2 + tol);
  endtask

  initial begin
    logic [31:0] v;
    bit ok;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    idle(10);
    rst_n = 1'b1;
    idle(20);

    // R1 reset values
    for (int a = 0; a <= 5; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg %0d", a), longint'(v), 0, 0);
    end
    chk("R1 fault outputs", longint'({flt_fast, flt_slow, flt_ref_lost}), 0, 0);

    // R4 width of duration
    wr(3'd1, 32'h001F_FFFF);
    rd(3'd1, v);
    chk("R4 duration width", longint'(v), 32'h000F_FFFF, 32'h000F_FFFF);

    // R2 start bit behaviour, R3 count
    wr(3'd1, 32'd100);
    wr(3'd0, 32'h1);
    rd(3'd0, v);
    chk("R2 start bit reads 1", longint'(v[0]), 1, 1);
    wait_done(ok);
    chk("R2 start bit self clears", longint'(ok), 1, 1);
    rd(3'd2, v);
    chk("R3 result 100 rc cycles", longint'(v), 249, 251);

    measure("R3 result 37 rc cycles", 37, 1);
    measure("R4 zero duration", 0, 2);

    // R5 start and duration writes while running are ignored
    wr(3'd1, 32'd100);
    wr(3'd0, 32'h1);
    idle(20);
    wr(3'd1, 32'd10);
    wr(3'd0, 32'h1);
    wait_done(ok);
    chk("R5 first run completes", longint'(ok), 1, 1);
    rd(3'd2, v);
    chk("R5 result from first duration", longint'(v), 249, 251);
    idle(400);
    rd(3'd0, v);
    chk("R5 no second run", longint'(v[0]), 0, 0);
    rd(3'd2, v);
    chk("R5 result unchanged", longint'(v), 249, 251);

    // R9 disabled monitor sets nothing
    wr(3'd3, 32'd10);
    wr(3'd4, 32'd0);
    idle(800);
    rd(3'd5, v);
    chk("R9 no faults while disabled", longint'(v), 0, 0);
    chk("R9 fault outputs low", longint'({flt_fast, flt_slow, flt_ref_lost}), 0, 0);

    // R11 divider lock, R8 negative
    wr(3'd3, 32'd60);
    wr(3'd4, 32'd40);
    wr(3'd0, 32'h22);
    wr(3'd0, 32'h32);
    rd(3'd0, v);
    chk("R11 divider locked while enabled", longint'(v[5:4]), 2, 2);
    chk("R11 enable set", longint'(v[1]), 1, 1);
    idle(800);
    rd(3'd5, v);
    chk("R8 in-range and running reference give no fault", longint'(v), 0, 0);

    // R6 too fast
    wr(3'd3, 32'd45);
    idle(400);
    rd(3'd5, v);
    chk("R6 fast flag", longint'(v), 1, 1);
    chk("R6 flt_fast output", longint'(flt_fast), 1, 1);

    // R10 sticky then cleared
    wr(3'd3, 32'd60);
    idle(300);
    rd(3'd5, v);
    chk("R10 fast flag sticky", longint'(v[0]), 1, 1);
    wr(3'd5, 32'h1);
    rd(3'd5, v);
    chk("R10 fast flag cleared", longint'(v), 0, 0);

    // R7 too slow
    wr(3'd4, 32'd58);
    idle(400);
    rd(3'd5, v);
    chk("R7 slow flag", longint'(v), 2, 2);
    chk("R7 flt_slow output", longint'(flt_slow), 1, 1);
    wr(3'd4, 32'd40);
    idle(300);
    wr(3'd5, 32'h2);
    rd(3'd5, v);
    chk("R10 slow flag cleared", longint'(v), 0, 0);

    // R8 reference loss
    ref_run = 1'b0;
    idle(150);
    rd(3'd5, v);
    chk("R8 lost flag", longint'(v[2]), 1, 1);
    chk("R8 flt_ref_lost output", longint'(flt_ref_lost), 1, 1);

    summary();
    $finish;
  end

endmodule